// File: doc/BRIEF.md
# Dual-Mode Shift-Based Multiply-Accumulate Element

This processing element sits in a neural-network accelerator array and forms weight-by-activation products without a multiplier. Each weight is coded in 4-bit power-of-two form. A product is made by arithmetically shifting the signed activation left and then negating it if the weight is negative. The shifted values are summed into 24-bit signed accumulators.

An 8-bit weight word is read in one of two ways. In the accurate mode both nibbles apply to activation 0, and their two shifted copies are added to form a single two-term product for accumulator 0. In the throughput mode the low nibble weights activation 0 into accumulator 0, and the high nibble weights activation 1 into accumulator 1. This gives two products per cycle from the same pair of shifters.

A two-state mode controller holds the active setting. Its states are ACCURATE (the reset state) and THROUGHPUT. The controller moves from ACCURATE to THROUGHPUT on a valid clearing input with `in_mode` = 1. It moves from THROUGHPUT to ACCURATE on a valid clearing input with `in_mode` = 0. In every other cycle it stays in its current state. The controller decodes the mode for the current cycle, which is the requested mode when that cycle clears the accumulators, and from that mode it enables each accumulator lane.

Top module: `shift_mac_pe`

## Requirements
- R1: After reset, `out_acc0` = 0, `out_acc1` = 0, `out_valid` = 0 and `out_mode` = 0 (accurate).
- R2: A 4-bit weight code has sign bit 3 (1 = negative) and exponent bits 2:0 = e. When e = 0 the term is 0. When e = 1 to 7 the term is ±activation·2^(e-1).
- R3: In accurate mode (`out_mode` = 0), a valid input adds term(w[3:0], act0) + term(w[7:4], act0) to accumulator 0, and accumulator 1 reads 0.
- R4: In throughput mode (`out_mode` = 1), a valid input adds term(w[3:0], act0) to accumulator 0 and adds term(w[7:4], act1) to accumulator 1.
- R5: A valid input with `in_clear` = 1 loads each updated accumulator with the current product instead of adding to it. A clear in accurate mode loads accumulator 1 with 0.
- R6: `in_mode` takes effect only in a valid input with `in_clear` = 1, and that input is already processed in the new mode. At any other time `in_mode` is ignored. `out_mode` shows the mode currently held.
- R7: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and the accumulator outputs show that input's effect in the same cycle.
- R8: While `in_valid` = 0, both accumulators and `out_mode` hold their values, whatever is on the other inputs.
- R9: The accumulators wrap modulo 2^24 on overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word is valid this cycle |
| in_clear | input | 1 | Load the accumulators instead of adding; also applies `in_mode` |
| in_mode | input | 1 | Requested mode: 0 accurate, 1 throughput |
| in_act0 | input | 8 | Signed activation for lane 0 |
| in_act1 | input | 8 | Signed activation for lane 1 (used in throughput mode only) |
| in_weight | input | 8 | Two 4-bit power-of-two codes; low nibble in bits 3:0 |
| out_valid | output | 1 | Result of the previous valid input is present |
| out_acc0 | output | 24 | Signed accumulator 0 |
| out_acc1 | output | 24 | Signed accumulator 1 |
| out_mode | output | 1 | Mode currently held: 0 accurate, 1 throughput |

## Verification
Each result is due one cycle after the input that caused it, because the accumulators, the mode state and `out_valid` all register at the same edge that captures a valid input. The driver applies each input on a falling edge. It pushes the expected accumulators, mode and valid flag for the following rising edge into a queue. The monitor pops one entry per cycle and compares it against the outputs one nanosecond after each rising edge. Idle cycles are queued too, so any change of the holding values and any `out_valid` produced in the wrong cycle is caught.

// File: rtl/shift_mac_pkg.sv
package shift_mac_pkg;
    localparam int ACT_W  = 8;
    localparam int ACC_W  = 24;
    localparam int CODE_W = 4;
    localparam int WORD_W = 2 * CODE_W;

    typedef enum logic {
        MODE_ACCURATE   = 1'b0,
        MODE_THROUGHPUT = 1'b1
    } pe_mode_e;
endpackage

// File: rtl/pe_term_shift.sv
module pe_term_shift #(
    parameter int ACT_W  = 8,
    parameter int ACC_W  = 24,
    parameter int CODE_W = 4
) (
    input  logic [ACT_W-1:0]        act,
    input  logic [CODE_W-1:0]       code,
    output logic signed [ACC_W-1:0] term
);
    localparam int EXP_W = CODE_W - 1;

    logic [EXP_W-1:0]        exp_f;
    logic                    neg_f;
    logic [EXP_W-1:0]        shamt;
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] mag;

    assign exp_f = code[EXP_W-1:0];
    assign neg_f = code[CODE_W-1];
    assign shamt = exp_f - EXP_W'(1);
    assign ext   = {{(ACC_W-ACT_W){act[ACT_W-1]}}, act};

    always_comb begin
        if (exp_f == '0) begin
            mag = '0;
        end else begin
            mag = ext <<< shamt;
        end
        term = neg_f ? -mag : mag;
    end
endmodule

// File: rtl/pe_mode_ctrl.sv
module pe_mode_ctrl
    import shift_mac_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  logic     in_clear,
    input  logic     in_mode,
    output pe_mode_e state_q,
    output pe_mode_e eff_mode,
    output logic     lane0_en,
    output logic     lane1_en,
    output logic     lane1_zero
);
    pe_mode_e state_d;
    logic     apply;

    assign apply = in_valid && in_clear;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_ACCURATE: begin
                if (apply && in_mode) state_d = MODE_THROUGHPUT;
            end
            MODE_THROUGHPUT: begin
                if (apply && !in_mode) state_d = MODE_ACCURATE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_ACCURATE;
        else        state_q <= state_d;
    end

    always_comb begin
        eff_mode   = apply ? pe_mode_e'(in_mode) : state_q;
        lane0_en   = in_valid;
        lane1_en   = 1'b0;
        lane1_zero = 1'b0;
        unique case (eff_mode)
            MODE_ACCURATE: begin
                lane1_en   = apply;
                lane1_zero = 1'b1;
            end
            MODE_THROUGHPUT: begin
                lane1_en   = in_valid;
                lane1_zero = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/pe_acc_lane.sv
module pe_acc_lane #(
    parameter int ACC_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    clr,
    input  logic signed [ACC_W-1:0] add_val,
    output logic signed [ACC_W-1:0] acc_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (en) begin
            if (clr) acc_q <= add_val;
            else     acc_q <= acc_q + add_val;
        end
    end
endmodule

// File: rtl/shift_mac_pe.sv
module shift_mac_pe
    import shift_mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_clear,
    input  logic              in_mode,
    input  logic [ACT_W-1:0]  in_act0,
    input  logic [ACT_W-1:0]  in_act1,
    input  logic [WORD_W-1:0] in_weight,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_acc0,
    output logic [ACC_W-1:0]  out_acc1,
    output logic              out_mode
);
    localparam int NTERM = WORD_W / CODE_W;

    pe_mode_e state_q;
    pe_mode_e eff_mode;
    logic     lane0_en;
    logic     lane1_en;
    logic     lane1_zero;
    logic     thr;

    logic [ACT_W-1:0]        sh_act  [NTERM];
    logic signed [ACC_W-1:0] sh_term [NTERM];
    logic signed [ACC_W-1:0] add0;
    logic signed [ACC_W-1:0] add1;
    logic signed [ACC_W-1:0] acc0_q;
    logic signed [ACC_W-1:0] acc1_q;

    pe_mode_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_clear  (in_clear),
        .in_mode   (in_mode),
        .state_q   (state_q),
        .eff_mode  (eff_mode),
        .lane0_en  (lane0_en),
        .lane1_en  (lane1_en),
        .lane1_zero(lane1_zero)
    );

    assign thr = (eff_mode == MODE_THROUGHPUT);

    // Shifter 0 always takes activation 0; shifter 1 is steered to act1 in throughput mode.
    assign sh_act[0] = in_act0;
    assign sh_act[1] = thr ? in_act1 : in_act0;

    for (genvar g = 0; g < NTERM; g++) begin : g_shift
        pe_term_shift #(
            .ACT_W (ACT_W),
            .ACC_W (ACC_W),
            .CODE_W(CODE_W)
        ) u_shift (
            .act (sh_act[g]),
            .code(in_weight[g*CODE_W +: CODE_W]),
            .term(sh_term[g])
        );
    end

    assign add0 = thr ? sh_term[0] : (sh_term[0] + sh_term[1]);
    assign add1 = lane1_zero ? '0 : sh_term[1];

    pe_acc_lane #(.ACC_W(ACC_W)) u_lane0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (lane0_en),
        .clr    (in_clear),
        .add_val(add0),
        .acc_q  (acc0_q)
    );

    pe_acc_lane #(.ACC_W(ACC_W)) u_lane1 (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (lane1_en),
        .clr    (in_clear),
        .add_val(add1),
        .acc_q  (acc1_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    assign out_acc0 = acc0_q;
    assign out_acc1 = acc1_q;
    assign out_mode = state_q;
endmodule

// File: rtl/shift_mac_pe_checker.sv
module shift_mac_pe_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_clear,
    input logic [7:0]  in_weight,
    input logic        out_valid,
    input logic [23:0] out_acc0,
    input logic [23:0] out_acc1,
    input logic        out_mode
);
    assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

    assert_acc1_zero_accurate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !out_mode |-> out_acc1 == 24'd0);

    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_acc0) && $stable(out_acc1) && $stable(out_mode));

    assert_mode_on_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode != $past(out_mode)) |-> $past(in_valid && in_clear));

    assert_zero_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_clear && in_weight[2:0] == 3'd0 && in_weight[6:4] == 3'd0)
        |=> $stable(out_acc0) && $stable(out_acc1));
endmodule

bind shift_mac_pe shift_mac_pe_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_clear (in_clear),
    .in_weight(in_weight),
    .out_valid(out_valid),
    .out_acc0 (out_acc0),
    .out_acc1 (out_acc1),
    .out_mode (out_mode)
);

// File: tb/shift_mac_pe_tb_top.sv
`timescale 1ns/1ps
module shift_mac_pe_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_clear = 1'b0, in_mode = 1'b0;
    logic [7:0]  in_act0 = '0, in_act1 = '0, in_weight = '0;
    logic        out_valid, out_mode;
    logic [23:0] out_acc0, out_acc1;

    always #2 clk = ~clk;

    shift_mac_pe dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_clear(in_clear),
        .in_mode(in_mode), .in_act0(in_act0), .in_act1(in_act1),
        .in_weight(in_weight), .out_valid(out_valid), .out_acc0(out_acc0),
        .out_acc1(out_acc1), .out_mode(out_mode)
    );

    typedef struct {
        logic        v;
        logic [23:0] a0;
        logic [23:0] a1;
        logic        m;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    logic [23:0] m_acc0 = '0, m_acc1 = '0;
    logic        m_mode = 1'b0;
    bit          done = 0;

    function automatic logic [23:0] term(input logic [7:0] a, input logic [3:0] c);
        int v = $signed(a);
        int e = int'(c[2:0]);
        int p = (e == 0) ? 0 : v * (1 << (e - 1));
        if (c[3]) p = -p;
        return p[23:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic drive(input logic v, input logic c, input logic md,
                         input logic [7:0] a0, input logic [7:0] a1,
                         input logic [7:0] w, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = v; in_clear = c; in_mode = md;
        in_act0 = a0; in_act1 = a1; in_weight = w;
        if (v) begin
            if (c) m_mode = md;
            if (!m_mode) begin
                m_acc0 = (c ? 24'd0 : m_acc0) + term(a0, w[3:0]) + term(a0, w[7:4]);
                if (c) m_acc1 = 24'd0;
            end else begin
                m_acc0 = (c ? 24'd0 : m_acc0) + term(a0, w[3:0]);
                m_acc1 = (c ? 24'd0 : m_acc1) + term(a1, w[7:4]);
            end
        end
        it.v = v; it.a0 = m_acc0; it.a1 = m_acc1; it.m = m_mode; it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk({it.tag, "/R7 valid"}, 32'(out_valid), 32'(it.v));
                chk({it.tag, " acc0"}, 32'(out_acc0), 32'(it.a0));
                chk({it.tag, " acc1"}, 32'(out_acc1), 32'(it.a1));
                chk({it.tag, " mode"}, 32'(out_mode), 32'(it.m));
            end
        end
    end

    initial begin : watchdog
        #400000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        #9 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acc0", 32'(out_acc0), 0);
        chk("R1 acc1", 32'(out_acc1), 0);
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 mode", 32'(out_mode), 0);

        // R2: every code, both signs of activation, in throughput mode with clear
        for (int c = 0; c < 16; c++) begin
            drive(1, 1, 1, 8'd5, 8'hF9, {4'(15 - c), 4'(c)}, "R2 code");
            drive(1, 1, 1, 8'h80, 8'd127, {4'(c), 4'(15 - c)}, "R2 extreme");
        end

        // R4: throughput accumulation on two lanes
        drive(1, 1, 1, 8'd3, 8'd10, 8'h32, "R4 start");
        for (int i = 0; i < 12; i++)
            drive(1, 0, 1, 8'(i * 7 - 40), 8'(90 - i * 13), 8'(i * 37 + 5), "R4 acc");

        // R8: idle with junk on inputs
        for (int i = 0; i < 4; i++)
            drive(0, 1, 0, 8'hAA, 8'h55, 8'hFF, "R8 idle");

        // R6: mode request without clear is ignored
        drive(1, 0, 0, 8'd9, 8'd4, 8'h21, "R6 ignored");

        // R3/R5: switch to accurate with clear, then accumulate two-term products
        drive(1, 1, 0, 8'd11, 8'd77, 8'h3B, "R5 clear accurate");
        for (int i = 0; i < 10; i++)
            drive(1, 0, 1, 8'(i * 19 - 90), 8'(i * 3), 8'(i * 53 + 9), "R3 acc");
        drive(1, 1, 0, 8'hF0, 8'd1, 8'hCF, "R5 clear again");
        drive(0, 0, 1, 8'd1, 8'd1, 8'h11, "R8 gap");
        drive(1, 0, 0, 8'd20, 8'd1, 8'h00, "R2 zero weight");

        // R9: wrap in accurate mode
        drive(1, 1, 0, 8'h80, 8'd0, 8'h77, "R9 start");
        for (int i = 0; i < 600; i++)
            drive(1, 0, 0, 8'h80, 8'd0, 8'h77, "R9 wrap");

        // R6: back to throughput on clear
        drive(1, 1, 1, 8'd2, 8'hFE, 8'hA5, "R6 switch");
        drive(1, 0, 0, 8'd2, 8'hFE, 8'hA5, "R4 after switch");
        for (int i = 0; i < 3; i++)
            drive(0, 0, 0, 8'd0, 8'd0, 8'd0, "R8 tail");

        @(posedge clk); #2;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule